// File: doc/BRIEF.md
# Flash Command Decoder with Erase Status

This block sits between a bus master and a block-partitioned NOR-style flash array. It watches chip enable, write enable and output enable. It decodes the command bytes that arrive on write cycles and chooses what a read cycle returns: array words, the status register or the extended status register. Only one kind of array operation is modelled, the two-cycle block erase. A cycle counter stands in for the physical erase time. At the end of that time every word of the target block is filled with ones.

Before an erase starts, the decoder checks three conditions: the programming-voltage-ok flag, the lock bit of the target block and the write-protect pin. Each refusal, and each malformed setup/confirm pair, sets its own pair of sticky error bits. Software reads these bits after the operation and clears them with an explicit command. The clear command does nothing while a suspend mode is flagged.

Top module: `flash_ci`

## Requirements
- R1: After reset `rdy_o` is high and reads return array contents. Every array word resets to 0. A bus write begins in the first cycle in which `ce_ni` and `we_ni` are both low. A read cycle begins in the first cycle in which `ce_ni` and `oe_ni` are both low.
- R2: The read mode is chosen by command bytes on `data_i`. 70h selects the status register and FFh selects array reads.
- R3: Writing 20h and then D0h erases a block. The D0h write carries an address inside the target block, and the block index is the upper address bits above the word offset. When the erase finishes, every word of that block reads FFFFh and other blocks are unchanged.
- R4: `rdy_o` goes low in the cycle of the confirm write and stays low for exactly ERASE_CYCLES clock cycles. Status bit 7 reads 1 only when `rdy_o` is high.
- R5: A status value captured while an erase runs reads 0000h. Bit 7 is 0, and every other bit is forced to 0 because it is not meaningful at that time.
- R6: The status value is captured once, at the start of each read cycle. It stays frozen for the rest of that cycle, even if the erase finishes during the cycle.
- R7: If the write that follows a 20h is anything other than D0h, status bits 4 (sequence error) and 5 (erase error) are set and nothing is erased.
- R8: If `vpp_ok_i` is low at confirm, status bits 3 (voltage error) and 5 are set. No erase starts, and `rdy_o` stays high.
- R9: If the target block's bit in `lock_i` is set and `wp_ni` is low at confirm, bits 1 (lock error) and 5 are set and the block is kept. If the lock bit is set and `wp_ni` is high, the erase proceeds.
- R10: Status bits 5, 4, 3 and 1 stay set across later successful erases until command 50h clears them. 50h has no effect while `suspend_i` is high.
- R11: Command E8h selects extended status reads, in which bit 7 reads 1 when no erase is running. The value is captured at the start of the first read cycle after the E8h, which is the later of the two enable falls. Later reads repeat that value until E8h is written again.
- R12: After an erase sequence, whether it starts or is refused, reads return the status register without a 70h command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the bus strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Word address: block index in the upper bits, word offset in the lower bits |
| data_i | input | 8 | Command byte |
| wp_ni | input | 1 | Write protect, active low; when low, lock bits are enforced |
| vpp_ok_i | input | 1 | Programming voltage above the lockout level |
| suspend_i | input | 1 | A suspend mode is active; blocks the clear-status command |
| lock_i | input | NUM_BLOCKS | Lock bit for each block |
| data_o | output | DATA_W | Read data |
| rdy_o | output | 1 | High when no erase is running |

## Verification
The bench builds the block with four blocks of four words and an erase time of eight cycles. With so few words, a test can probe both ends of the erased block and the words just outside it. The short erase time lets a single read cycle span an entire erase, so a status value captured as busy can be compared with the value from the next read cycle. It also keeps an extended-status strobe pair open across the end of an erase, with the second enable falling only after the erase has finished.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_XSTATUS} rd_mode_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_XSTATUS     = 8'hE8;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_SEQ_ERR   = 4;
  localparam int ST_VPP_ERR   = 3;
  localparam int ST_LOCK_ERR  = 1;

  localparam logic [7:0] STICKY_MASK = 8'b0011_1010;
endpackage

// File: rtl/flash_ci_strobe.sv
module flash_ci_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic en_ni,
  output logic start_o
);
  logic act, act_q;

  assign act     = !ce_ni && !en_ni;
  assign start_o = act && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end
endmodule

// File: rtl/flash_ci_erase.sv
module flash_ci_erase #(
  parameter int ERASE_CYCLES = 64,
  parameter int BLK_W        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] blk_o
);
  localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
      blk_q  <= blk_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign blk_o  = blk_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R4
endmodule

// File: rtl/flash_ci_status.sv
module flash_ci_status
  import flash_ci_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] set_i,
  input  logic       clr_i,
  input  logic       suspend_i,
  output logic [7:0] err_o
);
  logic [7:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= ((clr_i && !suspend_i) ? 8'h00 : err_q) | (set_i & STICKY_MASK);
  end

  assign err_o = err_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i || suspend_i) |=> ((err_q & $past(err_q)) == $past(err_q))); // R10
  AST_ERR_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[ST_LOCK_ERR] || err_q[ST_VPP_ERR] || err_q[ST_SEQ_ERR]) |-> err_q[ST_ERASE_ERR]); // R7
endmodule

// File: rtl/flash_ci_array.sv
module flash_ci_array #(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 16,
  parameter int DATA_W          = 16,
  localparam int BLK_W          = $clog2(NUM_BLOCKS),
  localparam int WRD_W          = $clog2(WORDS_PER_BLOCK),
  localparam int ADDR_W         = BLK_W + WRD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              erase_i,
  input  logic [BLK_W-1:0]  erase_blk_i
);
  localparam int NUM_WORDS = NUM_BLOCKS * WORDS_PER_BLOCK;

  logic [DATA_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
    end else if (erase_i) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (BLK_W'(w / WORDS_PER_BLOCK) == erase_blk_i) mem_q[w] <= '1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_FILL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> mem_q[{$past(erase_blk_i), {WRD_W{1'b0}}}] == '1); // R3
  AST_FILL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> mem_q[{$past(erase_blk_i), {WRD_W{1'b1}}}] == '1); // R3
endmodule

// File: rtl/flash_ci.sv
module flash_ci
  import flash_ci_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int WORDS_PER_BLOCK = 16,
  parameter int DATA_W          = 16,
  parameter int ERASE_CYCLES    = 64,
  localparam int BLK_W          = $clog2(NUM_BLOCKS),
  localparam int WRD_W          = $clog2(WORDS_PER_BLOCK),
  localparam int ADDR_W         = BLK_W + WRD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_ni,
  input  logic                  oe_ni,
  input  logic                  we_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            data_i,
  input  logic                  wp_ni,
  input  logic                  vpp_ok_i,
  input  logic                  suspend_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  output logic [DATA_W-1:0]     data_o,
  output logic                  rdy_o
);
  logic wr_start, rd_start;
  logic busy, done;
  logic [BLK_W-1:0] blk, erase_blk;
  logic [DATA_W-1:0] arr_data;
  logic [7:0] err, stat_now, set_err;
  logic erase_go, clr;

  rd_mode_e mode_q, mode_d;
  logic setup_q, setup_d, xarm_q, xarm_d;
  logic [7:0] stat_lat, xsr_lat;

  flash_ci_strobe u_wr (.clk_i, .rst_ni, .ce_ni, .en_ni(we_ni), .start_o(wr_start));
  flash_ci_strobe u_rd (.clk_i, .rst_ni, .ce_ni, .en_ni(oe_ni), .start_o(rd_start));

  flash_ci_erase #(.ERASE_CYCLES(ERASE_CYCLES), .BLK_W(BLK_W)) u_erase (
    .clk_i, .rst_ni, .start_i(erase_go), .blk_i(blk),
    .busy_o(busy), .done_o(done), .blk_o(erase_blk));

  flash_ci_status u_status (
    .clk_i, .rst_ni, .set_i(set_err), .clr_i(clr), .suspend_i, .err_o(err));

  flash_ci_array #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
                   .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .rd_data_o(arr_data),
    .erase_i(done), .erase_blk_i(erase_blk));

  assign blk      = addr_i[ADDR_W-1:WRD_W];
  assign stat_now = busy ? 8'h00 : (err | 8'h80);
  assign rdy_o    = !busy;

  always_comb begin
    mode_d   = mode_q;
    setup_d  = setup_q;
    xarm_d   = xarm_q;
    erase_go = 1'b0;
    set_err  = 8'h00;
    clr      = 1'b0;
    if (rd_start && mode_q == RD_XSTATUS) xarm_d = 1'b0;
    if (wr_start) begin
      if (setup_q) begin
        setup_d = 1'b0;
        mode_d  = RD_STATUS;
        if (data_i != CMD_CONFIRM)
          set_err = 8'h01 << ST_SEQ_ERR | 8'h01 << ST_ERASE_ERR;
        else if (!vpp_ok_i)
          set_err = 8'h01 << ST_VPP_ERR | 8'h01 << ST_ERASE_ERR;
        else if (lock_i[blk] && !wp_ni)
          set_err = 8'h01 << ST_LOCK_ERR | 8'h01 << ST_ERASE_ERR;
        else
          erase_go = 1'b1;
      end else begin
        unique case (data_i)
          CMD_ERASE_SETUP: if (!busy) setup_d = 1'b1;
          CMD_CLR_STATUS:  clr = 1'b1;
          CMD_RD_STATUS:   mode_d = RD_STATUS;
          CMD_RD_ARRAY:    mode_d = RD_ARRAY;
          CMD_XSTATUS: begin
            mode_d = RD_XSTATUS;
            xarm_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= RD_ARRAY;
      setup_q  <= 1'b0;
      xarm_q   <= 1'b0;
      stat_lat <= 8'h80;
      xsr_lat  <= 8'h80;
    end else begin
      mode_q  <= mode_d;
      setup_q <= setup_d;
      xarm_q  <= xarm_d;
      if (rd_start) stat_lat <= stat_now;
      if (rd_start && mode_q == RD_XSTATUS && xarm_q) xsr_lat <= busy ? 8'h00 : 8'h80;
    end
  end

  always_comb begin
    unique case (mode_q)
      RD_ARRAY:  data_o = arr_data;
      RD_STATUS: data_o = DATA_W'(stat_lat);
      default:   data_o = DATA_W'(xsr_lat);
    endcase
  end

  AST_NO_GO_LOW_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go |-> vpp_ok_i); // R8
  AST_LOCK_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_go && !wp_ni) |-> !lock_i[blk]); // R9
  AST_BUSY_STATUS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start && busy) |=> stat_lat == 8'h00); // R5
  AST_RDY_DROPS_ON_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go |=> !rdy_o); // R4
endmodule

// File: tb/flash_ci_tb_top.sv
`timescale 1ns/1ps
module flash_ci_tb_top;
  localparam int NB = 4, WPB = 4, DW = 16, EC = 8;
  localparam int AW = $clog2(NB) + $clog2(WPB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic wp_n = 1'b0, vpp_ok = 1'b1, susp = 1'b0;
  logic [NB-1:0] lock = '0;
  logic [DW-1:0] dout;
  logic rdy;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  event smp;

  always #2 clk = ~clk;

  flash_ci #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(WPB), .DATA_W(DW), .ERASE_CYCLES(EC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .wp_ni(wp_n), .vpp_ok_i(vpp_ok), .suspend_i(susp),
    .lock_i(lock), .data_o(dout), .rdy_o(rdy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the driver signals a sample point
  initial forever begin
    @(smp);
    if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", int'(dout), 0);
    else begin
      automatic logic [DW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(dout === e, t, int'(dout), int'(e));
    end
  end

  task automatic expect_rd(input logic [DW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic bus_write(input int a, input logic [7:0] c);
    @(negedge clk);
    addr = AW'(a); data = c; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input int a, input logic [DW-1:0] e, input string t);
    expect_rd(e, t);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ->smp;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!rdy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic erase(input int a);
    bus_write(a, 8'h20);
    bus_write(a, 8'hD0);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    #9 rst_n = 1'b1;
    @(negedge clk);
    check(rdy === 1'b1, "R1 ready after reset", int'(rdy), 1);
    bus_read(5, 16'h0000, "R1 array reset word");

    bus_write(0, 8'h70);
    bus_read(0, 16'h0080, "R2 status mode");
    bus_write(0, 8'hFF);
    bus_read(0, 16'h0000, "R2 array mode");

    erase(5);
    check(rdy === 1'b0, "R4 rdy low after confirm", int'(rdy), 0);
    wait_idle(n);
    check(n == EC, "R4 busy length", n, EC);
    bus_read(0, 16'h0080, "R12 status auto after erase");
    bus_write(0, 8'hFF);
    bus_read(4, 16'hFFFF, "R3 block first word");
    bus_read(7, 16'hFFFF, "R3 block last word");
    bus_read(3, 16'h0000, "R3 word below block");
    bus_read(8, 16'h0000, "R3 word above block");

    // status read held across a whole erase
    erase(9);
    expect_rd(16'h0000, "R5 status during erase");
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ->smp;
    wait_idle(n);
    @(negedge clk);
    expect_rd(16'h0000, "R6 frozen within read cycle");
    ->smp;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    bus_read(0, 16'h0080, "R6 refreshed on new read");

    bus_write(12, 8'h20);
    bus_write(12, 8'h70);
    bus_read(12, 16'h00B0, "R7 bad confirm bits");
    bus_write(0, 8'hFF);
    bus_read(12, 16'h0000, "R7 no erase");

    erase(1);
    wait_idle(n);
    bus_read(0, 16'h00B0, "R10 sticky across erase");
    bus_write(0, 8'hFF);
    bus_read(0, 16'hFFFF, "R3 block0 erased");

    susp = 1'b1;
    bus_write(0, 8'h50);
    bus_write(0, 8'h70);
    bus_read(0, 16'h00B0, "R10 clear ignored in suspend");
    susp = 1'b0;
    bus_write(0, 8'h50);
    bus_read(0, 16'h0080, "R10 clear works");

    vpp_ok = 1'b0;
    erase(13);
    check(rdy === 1'b1, "R8 no busy on low vpp", int'(rdy), 1);
    bus_read(13, 16'h00A8, "R8 vpp bits");
    vpp_ok = 1'b1;
    bus_write(0, 8'hFF);
    bus_read(13, 16'h0000, "R8 block kept");
    bus_write(0, 8'h50);

    lock = 4'b1000; wp_n = 1'b0;
    erase(14);
    bus_read(14, 16'h00A2, "R9 lock bits");
    bus_write(0, 8'hFF);
    bus_read(14, 16'h0000, "R9 locked block kept");
    bus_write(0, 8'h50);
    wp_n = 1'b1;
    erase(15);
    wait_idle(n);
    bus_read(0, 16'h0080, "R9 wp high status");
    bus_write(0, 8'hFF);
    bus_read(15, 16'hFFFF, "R9 wp high erases");
    lock = '0;

    bus_write(0, 8'hE8);
    bus_read(0, 16'h0080, "R11 xsr idle");
    bus_read(0, 16'h0080, "R11 xsr repeat");

    // oe falls during erase, ce falls after it ends: capture at the later fall
    erase(4);
    bus_write(0, 8'hE8);
    @(negedge clk);
    oe_n = 1'b0;
    wait_idle(n);
    expect_rd(16'h0080, "R11 xsr later edge");
    ce_n = 1'b0;
    @(negedge clk);
    ->smp;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;

    erase(4);
    bus_write(0, 8'hE8);
    bus_read(0, 16'h0000, "R11 xsr busy");
    wait_idle(n);
    bus_read(0, 16'h0000, "R11 xsr not refreshed");
    bus_write(0, 8'hE8);
    bus_read(0, 16'h0080, "R11 xsr refreshed by reissue");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule